// File: doc/BRIEF.md
# Timer Counter Control Unit

This block is the counting core of a general-purpose timer. A single 32-bit control word, written through a plain write strobe and always visible on a read port, selects where count ticks come from, whether the counter runs, and what happens when it stops. Ticks come from one of two sources. The first is a free-running prescaler on the bus clock that pulses once every `DIV_N` cycles. The second is an external count pin. That pin is synchronised into the bus clock domain and reduced to one-cycle pulses on either its rising or its falling edge.

Stopping the counter can also clear it. The clear happens only on a true run-to-stop transition and only while the clear-on-stop bit is set. A watchdog mode changes the meaning of the run bit. While the watchdog-disable input is low, a run request is absorbed into a hidden running state, so the run bit reads back as 0 but the counter keeps counting. Only raising watchdog-disable stops it. The interval, pulse and reserved mode codes all count the same way here, because output shaping and compare logic belong to neighbouring blocks.

Top module: `tmr_core`

## Requirements
- R1: After reset the read port returns 0 and the counter value is 0.
- R2: Control word fields: bit 7 run, bit 6 prescaler enable, bit 5 clear-on-stop, bit 3 edge select, bit 2 source select (0 prescaler, 1 external pin), bits 1:0 mode (00 interval, 01 pulse, 10 watchdog, 11 reserved). Bits 31:8 and bit 4 read as 0 and writes to them have no effect.
- R3: While running, the counter advances by one on each selected tick. While stopped, it holds its value.
- R4: Stopping the counter with clear-on-stop set clears it to 0. Stopping it with clear-on-stop clear only holds the value.
- R5: Setting clear-on-stop while the counter is already stopped leaves the counter value unchanged.
- R6: A single write that moves run=1/clear=0 to run=0/clear=1 both stops and clears the counter.
- R7: With the prescaler source selected, the counter advances exactly once every `DIV_N` bus cycles when the prescaler enable is 1, and does not advance when it is 0.
- R8: With the external source selected, each falling edge (edge select 0) or each rising edge (edge select 1) of the pin adds exactly one. The count appears `SYNC_STAGES`+1 cycles after the pin changes.
- R9: In watchdog mode with watchdog-disable low, writing run=1 starts counting, and the run bit reads back as 0 while counting continues. Raising watchdog-disable stops the counter and, if clear-on-stop is set, clears it.
- R10: The counter wraps from all-ones to 0.
- R11: A write takes effect at the clock edge that samples the strobe. Modes 00, 01 and 11 count identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word |
| ext_cnt_in | input | 1 | External count pin, asynchronous |
| wdog_off | input | 1 | Watchdog disable; high stops a watchdog-mode count |
| count_value | output | CNT_W | Counter value |

## Verification
The bench builds the block with `CNT_W` = 8 and `DIV_N` = 3, leaving `SYNC_STAGES` at 2. The narrow counter brings the all-ones-to-zero wrap within a few hundred cycles. The short prescaler period makes an exact ticks-per-window count cheap to check. With these values, run/stop/clear sequences, both pin edges, watchdog takeover and release, and several wraps all fit in one short run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_PULSE    = 2'b01,
        MODE_WDOG     = 2'b10,
        MODE_RSVD     = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      run;
        logic      div_en;
        logic      clr_en;
        logic      edge_rise;
        logic      src_ext;
        tmr_mode_e mode;
    } tmr_ctrl_t;

    localparam int BIT_RUN    = 7;
    localparam int BIT_DIV    = 6;
    localparam int BIT_CLR    = 5;
    localparam int BIT_EDGE   = 3;
    localparam int BIT_SRC    = 2;
    localparam int BIT_MODE_H = 1;
    localparam int BIT_MODE_L = 0;

    function automatic tmr_ctrl_t ctrl_from_word(input logic [31:0] w);
        tmr_ctrl_t c;
        c.run       = w[BIT_RUN];
        c.div_en    = w[BIT_DIV];
        c.clr_en    = w[BIT_CLR];
        c.edge_rise = w[BIT_EDGE];
        c.src_ext   = w[BIT_SRC];
        c.mode      = tmr_mode_e'(w[BIT_MODE_H:BIT_MODE_L]);
        return c;
    endfunction

    function automatic logic [31:0] word_from_ctrl(input tmr_ctrl_t c);
        logic [31:0] w;
        w                       = '0;
        w[BIT_RUN]              = c.run;
        w[BIT_DIV]              = c.div_en;
        w[BIT_CLR]              = c.clr_en;
        w[BIT_EDGE]             = c.edge_rise;
        w[BIT_SRC]              = c.src_ext;
        w[BIT_MODE_H:BIT_MODE_L] = c.mode;
        return w;
    endfunction

    localparam tmr_ctrl_t CTRL_RESET = '{run: 1'b0, div_en: 1'b0, clr_en: 1'b0,
                                         edge_rise: 1'b0, src_ext: 1'b0,
                                         mode: MODE_INTERVAL};

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    localparam int PW = (DIV_N > 1) ? $clog2(DIV_N) : 1;

    generate
        if (DIV_N <= 1) begin : g_passthru
            assign tick = enable;
        end else begin : g_divide
            logic [PW-1:0] phase_q;
            localparam logic [PW-1:0] LAST = PW'(DIV_N - 1);

            always_ff @(posedge clk) begin
                if (rst || !enable) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick = enable && (phase_q == LAST);

            // R7: prescaler ticks are never back to back when dividing
            p_tick_spaced_r7: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic sel_rise,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;
    logic                   rise_evt;
    logic                   fall_evt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[SYNC_STAGES-1];
    end

    assign rise_evt = chain_q[SYNC_STAGES-1] && !last_q;
    assign fall_evt = !chain_q[SYNC_STAGES-1] && last_q;
    assign pulse    = sel_rise ? rise_evt : fall_evt;

    // R8: each detected edge lasts one cycle
    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
        rise_evt |=> !rise_evt);
    p_fall_single_r8: assert property (@(posedge clk) disable iff (rst)
        fall_evt |=> !fall_evt);

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        wdog_off,
    output tmr_ctrl_t   ctrl,
    output logic        active,
    output logic        clear_evt,
    output logic [31:0] rd_data
);
    tmr_ctrl_t ctrl_q, cand, ctrl_d;
    logic      wd_live_q, wd_live_d;
    logic      active_d;

    always_comb begin
        cand      = wr_en ? ctrl_from_word(wr_data) : ctrl_q;
        ctrl_d    = cand;
        wd_live_d = 1'b0;
        if (cand.mode == MODE_WDOG && !wdog_off) begin
            wd_live_d  = wd_live_q | cand.run;
            ctrl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RESET;
            wd_live_q <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            wd_live_q <= wd_live_d;
        end
    end

    assign active    = ctrl_q.run | wd_live_q;
    assign active_d  = ctrl_d.run | wd_live_d;
    assign clear_evt = active && !active_d && ctrl_d.clr_en;
    assign ctrl      = ctrl_q;
    assign rd_data   = word_from_ctrl(ctrl_q);

    // R9: while the watchdog holds the count, the run bit reads 0
    p_wd_run_hidden_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_WDOG && !wdog_off && !$past(wdog_off)) |-> !rd_data[BIT_RUN]);
    // R2: reserved positions never read as 1
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:8] == '0 && !rd_data[4]);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_N       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             ext_cnt_in,
    input  logic             wdog_off,
    output logic [CNT_W-1:0] count_value
);
    tmr_ctrl_t        ctrl;
    logic             active;
    logic             clear_evt;
    logic             div_tick;
    logic             ext_tick;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;

    tmr_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wdog_off  (wdog_off),
        .ctrl      (ctrl),
        .active    (active),
        .clear_evt (clear_evt),
        .rd_data   (rd_data)
    );

    tmr_prescaler #(.DIV_N(DIV_N)) u_div (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl.div_en),
        .tick   (div_tick)
    );

    tmr_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_cnt_in),
        .sel_rise (ctrl.edge_rise),
        .pulse    (ext_tick)
    );

    assign tick = ctrl.src_ext ? ext_tick : div_tick;

    always_ff @(posedge clk) begin
        if (rst || clear_evt) begin
            cnt_q <= '0;
        end else if (active && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_value = cnt_q;

    // R3: a stopped counter holds
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(cnt_q));
    // R4: a stop with clear-on-stop lands on zero
    p_clear_on_stop_r4: assert property (@(posedge clk) disable iff (rst)
        clear_evt |=> cnt_q == '0);
    // R7: prescaler source with divide disabled never advances
    p_no_div_no_count_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.src_ext && !ctrl.div_en && !clear_evt) |=> $stable(cnt_q));
    // R10: the counter only steps by one or returns to zero
    p_step_or_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

endmodule

// File: tb/tmr_core_tb_top.sv
module tmr_core_tb_top;
    localparam int CNT_W = 8;
    localparam int DIV_N = 3;
    localparam int MASK  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             ext_cnt_in = 1'b0;
    logic             wdog_off = 1'b0;
    logic [CNT_W-1:0] count_value;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string tag     = "R1";

    always #4 clk = ~clk;

    tmr_core #(.CNT_W(CNT_W), .DIV_N(DIV_N), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ext_cnt_in(ext_cnt_in), .wdog_off(wdog_off), .count_value(count_value)
    );

    // behavioural reference
    int m_run, m_div, m_clr, m_edge, m_src, m_mode, m_wd, m_cnt, m_ph;
    int q_pin[$];
    int m_last;

    function automatic int ref_word();
        return (m_run << 7) | (m_div << 6) | (m_clr << 5) | (m_edge << 3) | (m_src << 2) | m_mode;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_div = 0; m_clr = 0; m_edge = 0; m_src = 0; m_mode = 0;
            m_wd = 0; m_cnt = 0; m_ph = 0; m_last = 0;
            q_pin = {0, 0};
        end else begin
            int sync_now, tk, was_on, now_on, nrun, ndiv, nclr, nedge, nsrc, nmode, nwd;
            sync_now = q_pin[0];
            if (m_src != 0)
                tk = m_edge ? (sync_now == 1 && m_last == 0) : (sync_now == 0 && m_last == 1);
            else
                tk = (m_div != 0 && m_ph == DIV_N - 1);
            was_on = m_run | m_wd;
            if (wr_en) begin
                nrun = wr_data[7]; ndiv = wr_data[6]; nclr = wr_data[5];
                nedge = wr_data[3]; nsrc = wr_data[2]; nmode = wr_data[1:0];
            end else begin
                nrun = m_run; ndiv = m_div; nclr = m_clr;
                nedge = m_edge; nsrc = m_src; nmode = m_mode;
            end
            nwd = 0;
            if (nmode == 2 && !wdog_off) begin
                nwd = m_wd | nrun;
                nrun = 0;
            end
            now_on = nrun | nwd;
            if (was_on && !now_on && nclr) m_cnt = 0;
            else if (was_on && tk)          m_cnt = (m_cnt + 1) & MASK;
            m_ph = (m_div != 0) ? ((m_ph == DIV_N - 1) ? 0 : m_ph + 1) : 0;
            m_last = sync_now;
            void'(q_pin.pop_front());
            q_pin.push_back(int'(ext_cnt_in));
            m_run = nrun; m_div = ndiv; m_clr = nclr; m_edge = nedge;
            m_src = nsrc; m_mode = nmode; m_wd = nwd;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison with the reference
    int prev_cnt = 0;
    bit saw_wrap = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({tag, " count"}, int'(count_value), m_cnt);
            chk({tag, " readback"}, int'(rd_data), ref_word());
            if (int'(count_value) < prev_cnt && count_value == '0) saw_wrap = 1;
            prev_cnt = int'(count_value);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    int c0;

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        chk("R1 reset readback", int'(rd_data), 0);
        chk("R1 reset count", int'(count_value), 0);

        tag = "R2";
        wr(32'hFFFF_FF7D);
        chk("R2 reserved masked", int'(rd_data), 32'h6D);
        wr(32'h0);

        tag = "R7";
        wr(32'hC0);
        c0 = int'(count_value);
        idle(30);
        chk("R7 one tick per DIV_N", (int'(count_value) - c0) & MASK, 10);

        tag = "R3";
        wr(32'h40);
        c0 = int'(count_value);
        idle(10);
        chk("R3 hold when stopped", int'(count_value), c0);
        wr(32'hC0);
        idle(9);
        chk("R3 resumes", (int'(count_value) - c0) & MASK, 3);

        tag = "R6";
        wr(32'h60);
        chk("R6 single write stops and clears", int'(count_value), 0);

        tag = "R4";
        wr(32'hE0);
        idle(12);
        wr(32'h60);
        chk("R4 clear on stop", int'(count_value), 0);
        wr(32'hC0);
        idle(12);
        wr(32'h40);
        c0 = int'(count_value);
        chk("R4 no clear without enable", int'(c0 != 0), 1);

        tag = "R5";
        wr(32'h60);
        idle(4);
        chk("R5 arming clear while stopped", int'(count_value), c0);

        tag = "R7";
        wr(32'h80);
        c0 = int'(count_value);
        idle(15);
        chk("R7 no advance without divide", int'(count_value), c0);

        tag = "R8";
        wr(32'h84);
        c0 = int'(count_value);
        for (int i = 0; i < 5; i++) begin
            ext_cnt_in = 1'b1; idle(4);
            ext_cnt_in = 1'b0; idle(4);
        end
        chk("R8 falling edges", (int'(count_value) - c0) & MASK, 5);
        wr(32'h8C);
        c0 = int'(count_value);
        ext_cnt_in = 1'b1; idle(2);
        chk("R8 latency not yet", int'(count_value), c0);
        idle(1);
        chk("R8 latency reached", (int'(count_value) - c0) & MASK, 1);
        ext_cnt_in = 1'b0; idle(4);
        for (int i = 0; i < 4; i++) begin
            ext_cnt_in = 1'b1; idle(4);
            ext_cnt_in = 1'b0; idle(4);
        end
        chk("R8 rising edges", (int'(count_value) - c0) & MASK, 5);

        tag = "R9";
        wdog_off = 1'b0;
        wr(32'hC2);
        chk("R9 run bit hidden", int'(rd_data[7]), 0);
        c0 = int'(count_value);
        idle(30);
        chk("R9 watchdog keeps counting", (int'(count_value) - c0) & MASK, 10);
        wdog_off = 1'b1;
        idle(2);
        c0 = int'(count_value);
        idle(9);
        chk("R9 disable stops", int'(count_value), c0);
        wdog_off = 1'b0;
        wr(32'hE2);
        idle(20);
        chk("R9 counting again", int'(count_value != 0), 1);
        wdog_off = 1'b1;
        idle(2);
        chk("R9 disable clears", int'(count_value), 0);

        tag = "R11";
        wdog_off = 1'b0;
        wr(32'hC3);
        c0 = int'(count_value);
        idle(30);
        chk("R11 reserved mode counts", (int'(count_value) - c0) & MASK, 10);
        wr(32'hC1);
        c0 = int'(count_value);
        idle(30);
        chk("R11 pulse mode counts", (int'(count_value) - c0) & MASK, 10);

        tag = "R10";
        saw_wrap = 0;
        idle(3 * (MASK + 1) + 30);
        chk("R10 wrap seen", int'(saw_wrap), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule